// File: doc/BRIEF.md
# Two-Bit Global-History Correlating Branch Predictor

This block predicts the direction of conditional branches. It keeps a short shift register holding the outcomes of the most recently resolved branches. That value picks one of several banks of 2-bit saturating counters. Within the chosen bank, a few address bits of the branch select the counter. A fetch stage presents a branch address on the lookup port and receives a taken or not-taken guess in the same cycle. The block also returns the history value it used, so the pipeline can carry that value alongside the branch.

When the branch resolves, the pipeline presents an update. The update carries the branch address, the real outcome and the history value captured at lookup time. The block trains exactly one counter: the one at that address in the bank named by the captured history. It then shifts the outcome into the live history register. Lookups and updates may occur in the same cycle. A lookup always sees the state as it was before that cycle's update.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset the history is 00 and every counter holds 1, so every lookup predicts not taken and `lk_hist` reads 0.
- R2: The prediction is taken exactly when the selected counter holds 2 or 3.
- R3: A lookup reads the bank whose number equals the live history and the entry given by address bits [5:2]. Address bits [1:0] and [31:6] have no effect on the result.
- R4: With `upd_valid` high, the counter in bank `upd_hist` at entry `upd_pc[5:2]` is adjusted. It goes up by one on taken and down by one on not taken, and it stays within 0 and 3.
- R5: An update changes only that one counter. All other entries of that bank, and all entries of the other three banks, keep their values.
- R6: On each update the history becomes {old bit 0, outcome}. Bit 0 is the newest branch, and 1 means taken, so 01 means the older branch was not taken and the newer one was taken.
- R7: With `upd_valid` low, neither the history nor any counter changes.
- R8: A counter at 3 still predicts taken after one not-taken update. It flips to not taken only after a second one. The same holds in the other direction from 0.
- R9: `lk_hist` always shows the live history register.
- R10: A lookup in the same cycle as an update returns the prediction and history from before that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | 32 | Branch address for lookup |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | 2 | Live global history used for this lookup |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_hist | input | 2 | History captured when that branch was predicted |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench drives one counter to 3 and another to 0, then pushes each past its limit. A design that wrapped instead of saturating would suddenly flip its prediction. The bench also trains a bank through an explicit `upd_hist` that differs from the live history. It then reaches the same entry from the other banks to show they were not touched, which exposes a design that trains with the live history or writes every bank. Lookups use addresses that vary only in the ignored bits, and lookups are placed in the same cycle as updates. These catch a wrong index slice or a prediction bypassed from the pending write. The history is followed bit by bit to catch a reversed shift order.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;
  localparam int BP_CTR_W   = 2;
  localparam int BP_CTR_MAX = (1 << BP_CTR_W) - 1;
  localparam int BP_CTR_RST = 1;

  typedef logic [BP_CTR_W-1:0] bp_ctr_t;

  // saturating step of one counter
  function automatic bp_ctr_t ctr_next(bp_ctr_t c, logic taken);
    bp_ctr_t r;
    r = c;
    if (taken && c != bp_ctr_t'(BP_CTR_MAX)) r = c + 1'b1;
    else if (!taken && c != '0)              r = c - 1'b1;
    return r;
  endfunction

  // upper half of the range means taken
  function automatic logic ctr_says_taken(bp_ctr_t c);
    return c[BP_CTR_W-1];
  endfunction
endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
  end
endmodule

// File: rtl/bp_ctr_bank.sv
module bp_ctr_bank
  import corr_bp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output bp_ctr_t          rd_ctr,
  input  logic [IDX_W-1:0] wr_idx,
  output bp_ctr_t          wr_cur,
  input  logic             wr_en,
  input  bp_ctr_t          wr_data
);
  localparam int ENTRIES = 1 << IDX_W;

  bp_ctr_t mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= bp_ctr_t'(BP_CTR_RST);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_ctr = mem[rd_idx];
  assign wr_cur = mem[wr_idx];
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
  import corr_bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 2,
  parameter int IDX_W   = 4,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken
);
  localparam int NUM_TABLES = 1 << HIST_W;
  localparam int IDX_MSB    = IDX_LSB + IDX_W - 1;

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [HIST_W-1:0] ghist;

  // named internal events for the checker
  logic [NUM_TABLES-1:0]          tbl_we;
  bp_ctr_t                        wr_old_ctr;
  bp_ctr_t                        wr_new_ctr;
  bp_ctr_t [NUM_TABLES-1:0]       rd_all;
  bp_ctr_t [NUM_TABLES-1:0]       cur_all;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_MSB+1], lk_pc[IDX_LSB-1:0],
                            upd_pc[PC_W-1:IDX_MSB+1], upd_pc[IDX_LSB-1:0]};

  assign lk_idx = lk_pc[IDX_MSB:IDX_LSB];
  assign wr_idx = upd_pc[IDX_MSB:IDX_LSB];

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist      (ghist)
  );

  genvar t;
  generate
    for (t = 0; t < NUM_TABLES; t++) begin : g_bank
      assign tbl_we[t] = upd_valid && (upd_hist == HIST_W'(t));
      bp_ctr_bank #(.IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_idx),
        .rd_ctr  (rd_all[t]),
        .wr_idx  (wr_idx),
        .wr_cur  (cur_all[t]),
        .wr_en   (tbl_we[t]),
        .wr_data (wr_new_ctr)
      );
    end
  endgenerate

  assign wr_old_ctr = cur_all[upd_hist];
  assign wr_new_ctr = ctr_next(wr_old_ctr, upd_taken);

  assign lk_hist  = ghist;
  assign lk_taken = ctr_says_taken(rd_all[ghist]);
endmodule

// File: rtl/corr_bp_chk.sv
module corr_bp_chk
  import corr_bp_pkg::*;
#(
  parameter int HIST_W = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      upd_valid,
  input logic                      upd_taken,
  input logic [HIST_W-1:0]         lk_hist,
  input logic [(1<<HIST_W)-1:0]    tbl_we,
  input bp_ctr_t                   wr_old_ctr,
  input bp_ctr_t                   wr_new_ctr
);
  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> lk_hist == {$past(lk_hist[HIST_W-2:0]), $past(upd_taken)});

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(lk_hist));

  // R5
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $countones(tbl_we) == 1);

  // R7
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> tbl_we == '0);

  // R4
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && wr_old_ctr == bp_ctr_t'(BP_CTR_MAX))
      |-> wr_new_ctr == bp_ctr_t'(BP_CTR_MAX));

  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && wr_old_ctr == '0) |-> wr_new_ctr == '0);
endmodule

bind corr_branch_predictor corr_bp_chk #(.HIST_W(HIST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .lk_hist    (lk_hist),
  .tbl_we     (tbl_we),
  .wr_old_ctr (wr_old_ctr),
  .wr_new_ctr (wr_new_ctr)
);

// File: tb/corr_branch_predictor_test.sv
`timescale 1ns/1ps
module corr_branch_predictor_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic [1:0]  lk_hist;
  logic        upd_valid = 0;
  logic [31:0] upd_pc = '0;
  logic [1:0]  upd_hist = '0;
  logic        upd_taken = 0;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int m_ctr [4][16];
  int m_hist;

  always #10 clk = ~clk;

  corr_branch_predictor uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken)
  );

  function automatic int entry_of(logic [31:0] pc);
    return int'((pc >> 2) & 32'hF);
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // one clock: drive, compare, then advance the model
  task automatic cyc(string tag, logic [31:0] pc, logic uv, logic [31:0] upc,
                     logic [1:0] uh, logic ut);
    int e;
    @(negedge clk);
    lk_pc = pc; upd_valid = uv; upd_pc = upc; upd_hist = uh; upd_taken = ut;
    #2;
    check({tag, " pred"}, int'(lk_taken), (m_ctr[m_hist][entry_of(pc)] >= 2) ? 1 : 0);
    check({tag, " hist R9"}, int'(lk_hist), m_hist);
    @(posedge clk);
    if (uv) begin
      e = entry_of(upc);
      if (ut && m_ctr[uh][e] < 3) m_ctr[uh][e]++;
      if (!ut && m_ctr[uh][e] > 0) m_ctr[uh][e]--;
      m_hist = ((m_hist << 1) | int'(ut)) & 3;
    end
  endtask

  task automatic lookup(string tag, logic [31:0] pc);
    cyc(tag, pc, 1'b0, 32'h0, 2'b00, 1'b0);
  endtask

  task automatic upd(string tag, logic [31:0] upc, logic [1:0] uh, logic ut);
    cyc(tag, 32'h0, 1'b1, upc, uh, ut);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 16; b++) m_ctr[a][b] = 1;
    m_hist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: every entry of the live bank predicts not taken
    for (int i = 0; i < 16; i++) lookup("R1", 32'(i) << 2);
    check("R1 explicit", int'(lk_taken), 0);

    // R4 R8: train bank 3 entry 5 up to saturation, with live history differing
    upd("R4", 32'h14, 2'b11, 1'b1);
    upd("R4", 32'h14, 2'b11, 1'b1);
    upd("R4", 32'h14, 2'b11, 1'b1);
    upd("R4", 32'h14, 2'b11, 1'b1);           // held at 3
    lookup("R2 R3", 32'hABC0_0014);            // live hist 11, entry 5: taken
    check("R8 strong taken", int'(lk_taken), 1);
    upd("R8", 32'h14, 2'b11, 1'b0);           // 3 -> 2, hist 10
    upd("R6", 32'h24, 2'b00, 1'b1);           // hist 01
    upd("R6", 32'h24, 2'b00, 1'b1);           // hist 11
    lookup("R8 one miss", 32'h0000_0017);      // bits[1:0] ignored
    check("R8 still taken", int'(lk_taken), 1);
    // R5: other banks untouched at entry 5
    upd("R6", 32'h38, 2'b01, 1'b0);           // hist 10
    lookup("R5 bank2", 32'h14);
    check("R5 bank2 untouched", int'(lk_taken), 0);
    upd("R6", 32'h38, 2'b01, 1'b0);           // hist 00
    lookup("R5 bank0", 32'h14);
    check("R6 history 00", int'(lk_hist), 0);

    // R4: saturate low, R8 from 0 needs two taken
    upd("R4", 32'h3C, 2'b00, 1'b0);
    upd("R4", 32'h3C, 2'b00, 1'b0);
    upd("R4", 32'h3C, 2'b00, 1'b0);           // held at 0
    upd("R8", 32'h3C, 2'b00, 1'b1);           // 1, hist 01
    upd("R8", 32'h3C, 2'b00, 1'b1);           // 2, hist 11
    upd("R6", 32'h3C, 2'b11, 1'b0);           // hist 10
    upd("R6", 32'h3C, 2'b11, 1'b0);           // hist 00
    lookup("R8 bank0 e15", 32'hFFFF_FFFC);
    check("R8 flipped", int'(lk_taken), 1);

    // R7: idle cycles change nothing
    for (int i = 0; i < 8; i++) lookup("R7", 32'(i * 52));

    // R10 with R2 R3 R4 R5 R6: random traffic including same-cycle lookups
    for (int i = 0; i < 3000; i++) begin
      logic uv;
      logic [1:0] uh;
      uv = ($urandom_range(0, 3) != 0);
      uh = ($urandom_range(0, 1) != 0) ? 2'(m_hist) : 2'($urandom_range(0, 3));
      cyc("R10 random", $urandom, uv, $urandom, uh, 1'($urandom_range(0, 1)));
    end

    // R1 again after a mid-run reset
    @(negedge clk);
    rst_n = 0; upd_valid = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 16; b++) m_ctr[a][b] = 1;
    m_hist = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 16; i++) lookup("R1 rereset", 32'(i) << 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule